// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block runs from the crystal oscillator clock and produces two kinds of output. The first is a clock for an external host controller, divided from the oscillator by 3, 6 or 12 as chosen by a 2-bit control code, or switched off with the pin held low. Every enabled ratio, including the odd ratio of 3, has a 50% duty cycle. A divide-by-3 output cannot have an even split on one clock edge, so the block combines a rising-edge phase flag with a copy of that flag taken on the falling edge.

The second output is a pair of one-cycle enable strobes for the rest of the digital logic. A base tick fires once every 16 oscillator cycles. A scaled tick fires on every 8th, 4th, 2nd or every base tick, as chosen by a 2-bit rate range. These strobes are enables in the oscillator clock domain, not derived clocks.

A new control code is applied only at the end of a complete output period, so the host clock never shows a runt pulse or a shortened high phase. A new rate range is applied at the next base tick and restarts the scaled count there. A standby/active mode input is accepted, but the output clock runs the same way in both modes.

Top module: `xto_clock_divider`

## Requirements
- R1: While rstN is low, clkOut, baseTick and scaledTick are all 0, whatever outCtrl holds.
- R2: With outCtrl = 2'b00 the output is off: clkOut stays low and shows no rising edge for as long as the code is held.
- R3: With outCtrl = 2'b01, clkOut has a period of 3 oscillator cycles, high for 1.5 cycles and low for 1.5 cycles.
- R4: With outCtrl = 2'b10, clkOut has a period of 6 cycles (3 high, 3 low). With 2'b11 it has a period of 12 cycles (6 high, 6 low).
- R5: When a ratio is enabled from the off state, clkOut first stays low and its first high phase has full length.
- R6: A change of outCtrl takes effect only at the rising oscillator edge that ends a full output period. The high phase in progress always completes at full length, and a code that is reverted before that edge has no effect. The new ratio then starts with its low phase. That low phase lasts 2 cycles when entering /3, and N/2 cycles when entering /N, or N/2 − 0.5 cycles when leaving /3.
- R7: The standby input has no effect on clkOut, baseTick or scaledTick.
- R8: baseTick is high for exactly one cycle in every 16. Counting the rising edges after reset release from 1, it is high in the cycle that follows edge n whenever n mod 16 = 15.
- R9: scaledTick is high only in a cycle where baseTick is high. Reset selects range 0. With rateRange 0, 1, 2 or 3 held, it fires on every 8th, 4th, 2nd or every base tick, and the first fires on the 8th base tick after reset.
- R10: At the first base tick where rateRange differs from the applied range, the new range is applied, no scaled tick is given, and the count restarts. The next scaled tick then comes L base ticks later, where L is the new range's spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkXto | input | 1 | Crystal oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| outCtrl | input | 2 | Output clock code: 00 off, 01 /3, 10 /6, 11 /12 |
| rateRange | input | 2 | Scaled tick spacing: 0→8, 1→4, 2→2, 3→1 base ticks |
| standby | input | 1 | Mode indication, 1 = standby, 0 = active |
| clkOut | output | 1 | Divided host clock, parked low when off |
| baseTick | output | 1 | One-cycle strobe every 16 oscillator cycles |
| scaledTick | output | 1 | One-cycle strobe on the selected base ticks |

## Verification
clkOut changes only on oscillator edges: the phase flag changes on the rising edge and the odd-ratio extension on the falling edge. A code change is seen at the end of the current period, or on the next rising edge when the output is off. The bench therefore samples clkOut 2 ns after every edge, measures each high and low run in half cycles, and compares each finished run against a queue of expected runs that the driver pushes after it has aligned itself to a detected rising edge. The strobes are registered one edge after the internal count reaches its compare value, so they are checked at the falling edge inside the cycle that follows edge n. A model of the spacing rules reads the rate range, which the bench only changes far from base tick edges.

// File: rtl/xcd_pkg.sv
`timescale 1ns/1ps
package xcd_pkg;

  // Output clock selection; the code values are the outCtrl encodings.
  typedef enum logic [1:0] {
    SEL_OFF  = 2'b00,
    SEL_DIV1 = 2'b01,
    SEL_DIV2 = 2'b10,
    SEL_DIV4 = 2'b11
  } outSel_e;

  // Strobes from the ratio control to the divider datapath.
  typedef struct packed {
    outSel_e selCur;   // ratio in force this cycle
    outSel_e selNext;  // ratio in force after the next rising edge
    logic    restart;  // next rising edge starts a fresh period
  } divStrobe_t;

endpackage

// File: rtl/xcd_ratio_ctrl.sv
`timescale 1ns/1ps
module xcd_ratio_ctrl
  import xcd_pkg::*;
(
  input  logic       clkXto,
  input  logic       rstN,
  input  logic [1:0] outCtrl,
  input  logic       atEnd,
  output divStrobe_t strb
);

  outSel_e curSel;
  outSel_e selNext;
  logic    loadNow;

  // A new code is accepted when off, or on the edge that closes a period.
  always_comb begin
    loadNow = (curSel == SEL_OFF) || atEnd;
    selNext = loadNow ? outSel_e'(outCtrl) : curSel;
  end

  always_ff @(posedge clkXto or negedge rstN) begin
    if (!rstN) curSel <= SEL_OFF;
    else       curSel <= selNext;
  end

  always_comb begin
    strb.selCur  = curSel;
    strb.selNext = selNext;
    strb.restart = loadNow;
  end

  // R6: the applied ratio moves only from off or at a period boundary
  a_r6_switch_at_end: assert property (@(posedge clkXto) disable iff (!rstN)
    (curSel != $past(curSel)) |-> ($past(curSel) == SEL_OFF || $past(atEnd)));

endmodule

// File: rtl/xcd_div_datapath.sv
`timescale 1ns/1ps
module xcd_div_datapath
  import xcd_pkg::*;
#(
  parameter int ODD_DIV = 3
)(
  input  logic       clkXto,
  input  logic       rstN,
  input  divStrobe_t strb,
  output logic       atEnd,
  output logic       clkOut
);

  localparam int CNT_W = $clog2(4 * ODD_DIV);
  localparam logic [CNT_W-1:0] LEN1 = CNT_W'(ODD_DIV);
  localparam logic [CNT_W-1:0] LEN2 = CNT_W'(2 * ODD_DIV);
  localparam logic [CNT_W-1:0] LEN4 = CNT_W'(4 * ODD_DIV);

  function automatic logic [CNT_W-1:0] lenOf(input outSel_e s);
    case (s)
      SEL_DIV1: lenOf = LEN1;
      SEL_DIV2: lenOf = LEN2;
      SEL_DIV4: lenOf = LEN4;
      default:  lenOf = '0;
    endcase
  endfunction

  logic [CNT_W-1:0] cnt, cntNext, lenCur, lenNext;
  logic [CNT_W:0]   hiStart;
  logic             hiNext;
  logic             posFlag, negFlag;

  always_comb begin
    lenCur  = lenOf(strb.selCur);
    lenNext = lenOf(strb.selNext);
    atEnd   = (strb.selCur != SEL_OFF) && (cnt == lenCur - CNT_W'(1));
    cntNext = (strb.selNext == SEL_OFF || strb.restart) ? '0 : cnt + CNT_W'(1);
    // High region is the upper part of the period: ceil(len/2) onward.
    hiStart = ({1'b0, lenNext} + (CNT_W+1)'(1)) >> 1;
    hiNext  = (strb.selNext != SEL_OFF) && ({1'b0, cntNext} >= hiStart);
  end

  always_ff @(posedge clkXto or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      posFlag <= 1'b0;
    end else begin
      cnt     <= cntNext;
      posFlag <= hiNext;
    end
  end

  // Falling-edge copy stretches the odd-ratio high phase by half a cycle.
  always_ff @(negedge clkXto or negedge rstN) begin
    if (!rstN) negFlag <= 1'b0;
    else       negFlag <= posFlag && (strb.selCur == SEL_DIV1);
  end

  assign clkOut = posFlag | negFlag;

  // R2: with the output off and no half-cycle tail, the pin is low
  a_r2_off_low: assert property (@(posedge clkXto) disable iff (!rstN)
    (strb.selCur == SEL_OFF && !negFlag) |-> !clkOut);

  // R4: an even-ratio high phase lasts more than one cycle
  a_r4_even_high_hold: assert property (@(posedge clkXto) disable iff (!rstN)
    ($rose(posFlag) && strb.selCur != SEL_DIV1) |=> posFlag);

  // R3: the phase counter never leaves the active period
  a_r3_cnt_bound: assert property (@(posedge clkXto) disable iff (!rstN)
    (strb.selCur != SEL_OFF) |-> (cnt < lenCur));

endmodule

// File: rtl/xcd_timebase.sv
`timescale 1ns/1ps
module xcd_timebase #(
  parameter int BASE_DIV  = 16,
  parameter int RANGE_W   = 2,
  parameter int SCALE_MAX = 8
)(
  input  logic               clkXto,
  input  logic               rstN,
  input  logic [RANGE_W-1:0] rateRange,
  output logic               baseTick,
  output logic               scaledTick
);

  localparam int BASE_W = $clog2(BASE_DIV);
  localparam int SC_W   = (SCALE_MAX > 1) ? $clog2(SCALE_MAX) : 1;

  logic [BASE_W-1:0]  baseCnt;
  logic [SC_W-1:0]    scCnt, lastIdx;
  logic [RANGE_W-1:0] rangeCur;
  logic               preTick;

  always_comb begin
    preTick = (baseCnt == BASE_W'(BASE_DIV - 2));
    lastIdx = SC_W'((SCALE_MAX >> rangeCur) - 1);
  end

  always_ff @(posedge clkXto or negedge rstN) begin
    if (!rstN) begin
      baseCnt  <= '0;
      baseTick <= 1'b0;
    end else begin
      baseCnt  <= (baseCnt == BASE_W'(BASE_DIV - 1)) ? '0 : baseCnt + BASE_W'(1);
      baseTick <= preTick;
    end
  end

  always_ff @(posedge clkXto or negedge rstN) begin
    if (!rstN) begin
      scCnt      <= '0;
      rangeCur   <= '0;
      scaledTick <= 1'b0;
    end else if (preTick) begin
      if (rateRange != rangeCur) begin
        rangeCur   <= rateRange;
        scCnt      <= '0;
        scaledTick <= 1'b0;
      end else begin
        scaledTick <= (scCnt == lastIdx);
        scCnt      <= (scCnt == lastIdx) ? '0 : scCnt + SC_W'(1);
      end
    end else begin
      scaledTick <= 1'b0;
    end
  end

  // R8: the base strobe is a single-cycle pulse
  a_r8_one_cycle: assert property (@(posedge clkXto) disable iff (!rstN)
    baseTick |=> !baseTick);

  // R9: a scaled strobe only rides on a base strobe
  a_r9_inside_base: assert property (@(posedge clkXto) disable iff (!rstN)
    scaledTick |-> baseTick);

  // R10: the tick that applies a new range gives no scaled strobe
  a_r10_restart_quiet: assert property (@(posedge clkXto) disable iff (!rstN)
    (rangeCur != $past(rangeCur)) |-> !scaledTick);

endmodule

// File: rtl/xto_clock_divider.sv
`timescale 1ns/1ps
module xto_clock_divider
  import xcd_pkg::*;
#(
  parameter int ODD_DIV   = 3,
  parameter int BASE_DIV  = 16,
  parameter int SCALE_MAX = 8
)(
  input  logic       clkXto,
  input  logic       rstN,
  input  logic [1:0] outCtrl,
  input  logic [1:0] rateRange,
  input  logic       standby,
  output logic       clkOut,
  output logic       baseTick,
  output logic       scaledTick
);

  divStrobe_t divStrb;
  logic       atEnd;

  // R7: the mode input deliberately drives nothing
  logic unusedModeIn;
  assign unusedModeIn = standby;

  xcd_ratio_ctrl u_ctrl (
    .clkXto (clkXto),
    .rstN   (rstN),
    .outCtrl(outCtrl),
    .atEnd  (atEnd),
    .strb   (divStrb)
  );

  xcd_div_datapath #(.ODD_DIV(ODD_DIV)) u_path (
    .clkXto(clkXto),
    .rstN  (rstN),
    .strb  (divStrb),
    .atEnd (atEnd),
    .clkOut(clkOut)
  );

  xcd_timebase #(
    .BASE_DIV (BASE_DIV),
    .RANGE_W  (2),
    .SCALE_MAX(SCALE_MAX)
  ) u_tbase (
    .clkXto    (clkXto),
    .rstN      (rstN),
    .rateRange (rateRange),
    .baseTick  (baseTick),
    .scaledTick(scaledTick)
  );

endmodule

// File: tb/xto_clock_divider_bench.sv
`timescale 1ns/1ps
module xto_clock_divider_bench;

  localparam int CLK_PERIOD = 10;
  localparam int END_EDGE   = 1600;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] outCtrl = 2'b00;
  logic [1:0] rateRange = 2'b00;
  logic       standby = 1'b0;
  logic       clkOut, baseTick, scaledTick;

  int checks = 0;
  int errors = 0;
  int edgeN = 0;
  bit finished = 0;

  typedef struct {
    logic  lvl;
    int    halves;   // 0 = length not checked
    string tag;
  } runItem_t;

  runItem_t expQ[$];

  xto_clock_divider u_xto_clock_divider (
    .clkXto(clk), .rstN(rstN), .outCtrl(outCtrl), .rateRange(rateRange),
    .standby(standby), .clkOut(clkOut), .baseTick(baseTick), .scaledTick(scaledTick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rstN) edgeN++;

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic pushRun(input logic lvl, input int halves, input string tag);
    runItem_t it;
    it.lvl = lvl; it.halves = halves; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic waitDrained();
    while (expQ.size() != 0) begin
      @(clk);
      #3;
    end
  endtask

  // Scoreboard monitor: measures every level run in half cycles.
  initial begin
    logic prevLvl;
    int   runLen;
    runItem_t it;
    wait (rstN);
    prevLvl = 1'b0;
    runLen = 0;
    forever begin
      @(clk);
      #2;
      if (clkOut === prevLvl) runLen++;
      else begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R2/R6: unexpected run level=%0b len=%0d, expected no change", prevLvl, runLen);
        end else begin
          it = expQ.pop_front();
          if (it.lvl !== prevLvl || (it.halves != 0 && it.halves != runLen)) begin
            errors++;
            $display("FAIL %s: run level=%0b halves=%0d, expected level=%0b halves=%0d",
                     it.tag, prevLvl, runLen, it.lvl, it.halves);
          end
        end
        prevLvl = clkOut;
        runLen = 1;
      end
    end
  end

  // Tick checker with a spacing model built from R8..R10.
  initial begin
    int  rangeModel;
    int  k;
    int  lim;
    bit  expBase, expSc, afterChange;
    rangeModel = 0; k = 0; afterChange = 0;
    wait (rstN);
    forever begin
      @(negedge clk);
      if (edgeN > 0 && edgeN <= END_EDGE) begin
        expBase = (edgeN % 16 == 15);
        expSc = 0;
        if (expBase) begin
          if (int'(rateRange) != rangeModel) begin
            rangeModel = int'(rateRange);
            k = 0;
            afterChange = 1;
          end else begin
            lim = 8 >> rangeModel;
            expSc = (k == lim - 1);
            k = (k == lim - 1) ? 0 : k + 1;
          end
        end
        checks++;
        if (baseTick !== expBase) begin
          errors++;
          $display("FAIL R8: edge %0d baseTick=%0b expected %0b", edgeN, baseTick, expBase);
        end
        checks++;
        if (scaledTick !== expSc) begin
          errors++;
          $display("FAIL %s: edge %0d scaledTick=%0b expected %0b",
                   afterChange ? "R10" : "R9", edgeN, scaledTick, expSc);
        end
        if (expSc) afterChange = 0;
      end
    end
  end

  // R7: the mode input toggles throughout the run
  initial begin
    forever begin
      repeat (37) @(negedge clk);
      #1 standby = ~standby;
    end
  end

  // Watchdog
  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    // R1: reset holds all outputs low even with a ratio requested
    outCtrl = 2'b01;
    repeat (5) @(negedge clk);
    checks++;
    if (clkOut !== 1'b0 || baseTick !== 1'b0 || scaledTick !== 1'b0) begin
      errors++;
      $display("FAIL R1: outputs %0b%0b%0b in reset, expected 000", clkOut, baseTick, scaledTick);
    end
    outCtrl = 2'b00;
    @(negedge clk);
    rstN = 1'b1;

    fork
      begin
        repeat (20) @(negedge clk);
        // R2: code 00 after reset keeps the pin low
        checks++;
        if (clkOut !== 1'b0) begin
          errors++;
          $display("FAIL R2: clkOut=%0b while off, expected 0", clkOut);
        end
        #3;
        // R5, R3: enable /3 from off
        outCtrl = 2'b01;
        pushRun(0, 0, "R5"); pushRun(1, 3, "R5"); pushRun(0, 3, "R3");
        pushRun(1, 3, "R3"); pushRun(0, 3, "R3");
        waitDrained();
        // R6: /3 to /6
        outCtrl = 2'b10;
        pushRun(1, 3, "R6"); pushRun(0, 5, "R6"); pushRun(1, 6, "R4"); pushRun(0, 6, "R4");
        waitDrained();
        // R6: a code pulse reverted before the period end is ignored
        outCtrl = 2'b11;
        #(CLK_PERIOD);
        outCtrl = 2'b10;
        pushRun(1, 6, "R6"); pushRun(0, 6, "R6"); pushRun(1, 6, "R4"); pushRun(0, 6, "R4");
        waitDrained();
        // R6, R4: /6 to /12
        outCtrl = 2'b11;
        pushRun(1, 6, "R6"); pushRun(0, 12, "R6"); pushRun(1, 12, "R4"); pushRun(0, 12, "R4");
        waitDrained();
        // R6: /12 to /3
        outCtrl = 2'b01;
        pushRun(1, 12, "R6"); pushRun(0, 4, "R6"); pushRun(1, 3, "R3"); pushRun(0, 3, "R3");
        waitDrained();
        // R6, R2: /3 to off, high phase completes then parks low
        outCtrl = 2'b00;
        pushRun(1, 3, "R6");
        waitDrained();
        begin
          bit sawHigh;
          sawHigh = 0;
          for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            #2;
            if (clkOut !== 1'b0) sawHigh = 1;
          end
          checks++;
          if (sawHigh) begin
            errors++;
            $display("FAIL R2: clkOut went high while off, expected 0");
          end
        end
        // R5, R4: /6 from off, then off again
        outCtrl = 2'b10;
        pushRun(0, 0, "R5"); pushRun(1, 6, "R5"); pushRun(0, 6, "R4");
        waitDrained();
        outCtrl = 2'b00;
        pushRun(1, 6, "R6");
        waitDrained();
      end
      begin
        // R9, R10: walk through every range, changes far from base ticks
        wait (edgeN == 260); @(negedge clk); #1 rateRange = 2'd1;
        wait (edgeN == 516); @(negedge clk); #1 rateRange = 2'd2;
        wait (edgeN == 772); @(negedge clk); #1 rateRange = 2'd3;
        wait (edgeN == 1028); @(negedge clk); #1 rateRange = 2'd0;
        wait (edgeN == 1300); @(negedge clk); #1 rateRange = 2'd2;
        wait (edgeN == END_EDGE + 2);
      end
    join
    finishRun();
  end

endmodule